// File: doc/BRIEF.md
# Hardware Address Breakpoint Controller

This block watches the processor address bus for one programmable 16-bit address. Software loads the address as two bytes and turns the feature on with an enable bit. When a valid bus cycle carries that address, the block sets a break-active flag. It then asks the processor to take a break at the next instruction boundary. If the match lands on the last cycle of an instruction, the break is taken at once.

When the break is taken, the block raises a one-cycle take pulse. In the same cycle it presents the software-interrupt opcode for the processor to inject, together with the address of the vector to fetch. That vector address depends on whether the processor is in monitor mode. While the break flag is set, the block freezes the timer counter. In the same state it withholds permission to clear status flags, unless a separate permit bit allows clearing during a break. Software ends the break by writing zero to the flag.

Top module: `brk_addr_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `timerFreeze` and `breakTake` are low, `swiOpcode` is 0x00 and `flagClrAllow` is high.
- R2: `regSel` picks the register. Select 0 is the address high byte and select 1 is the address low byte, both read/write. Select 2 is status and control: bit 7 is enable and bit 6 is the active flag. Select 3 is flag control, with the clear-permit bit in bit 7. All other bits of selects 2 and 3 read 0. `regRdata` follows `regSel` with no clock delay.
- R3: A match requires `busValid` high, enable set, and `busAddr` equal to {high byte, low byte} in all 16 bits. With enable clear, or with any address bit different, nothing happens.
- R4: A match sets the active flag (status bit 6) at the clock edge that ends the matching cycle.
- R5: If `lastCycle` is low during the match, the break is held pending. `breakTake` then goes high in the cycle after the cycle in which `instrDone` is high.
- R6: If `lastCycle` is high during the match, `breakTake` is high in the very next cycle.
- R7: `breakTake` lasts exactly one cycle. While the active flag is set, further matches start no new break.
- R8: When `breakTake` is high, `swiOpcode` is 0x83; otherwise it is 0x00. `vecAddr` is 0xFFFC when `monitorMode` is low and 0xFEFC when it is high.
- R9: `timerFreeze` is high exactly while the active flag is set.
- R10: `flagClrAllow` is low while the active flag is set and the clear-permit bit is 0. In all other cases it is high.
- R11: Writing status bit 6 as 0 clears the active flag and cancels a pending break. Writing it as 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| busAddr | input | 16 | Processor bus address |
| busValid | input | 1 | Bus cycle valid |
| lastCycle | input | 1 | Current bus cycle is the last one of its instruction |
| instrDone | input | 1 | Instruction boundary reached |
| monitorMode | input | 1 | Monitor mode selects the alternate vector |
| breakTake | output | 1 | One-cycle break-take pulse |
| swiOpcode | output | 8 | Opcode to inject while taking the break |
| vecAddr | output | 16 | Address of the vector high byte |
| timerFreeze | output | 1 | Stops the timer counter during a break |
| flagClrAllow | output | 1 | Status flags may be cleared |

## Verification
Reads through `regRdata`, `vecAddr`, `swiOpcode` and `flagClrAllow` are combinational. The bench checks them shortly after driving the select, before the next edge. The active flag, and with it `timerFreeze`, changes at the edge that closes the matching cycle. The bench checks it at the following falling edge. `breakTake` is a register output, so it is due one cycle after the match when `lastCycle` is high, and one cycle after the `instrDone` cycle otherwise. The checks sample at that falling edge and again one cycle later to confirm the pulse has ended.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int EN_BIT = 7;
  localparam int ACT_BIT = 6;
  localparam int PERMIT_BIT = 7;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_FLAG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic wrStat;
    logic wrFlag;
  } strobe_t;
endpackage

// File: rtl/brk_dp.sv
module brk_dp
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        regSel,
  input  logic              activeFlag,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  output logic              hit,
  output logic              permit,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] addrHi, addrLo;
  logic enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi <= '0;
      addrLo <= '0;
      enable <= 1'b0;
      permit <= 1'b0;
    end else begin
      if (stb.wrHi)   addrHi <= wdata;
      if (stb.wrLo)   addrLo <= wdata;
      if (stb.wrStat) enable <= wdata[EN_BIT];
      if (stb.wrFlag) permit <= wdata[PERMIT_BIT];
    end
  end

  assign hit = busValid && enable && (busAddr == {addrHi, addrLo});

  always_comb begin
    rdata = '0;
    unique case (regSel_e'(regSel))
      SEL_HI:   rdata = addrHi;
      SEL_LO:   rdata = addrLo;
      SEL_STAT: begin
        rdata[EN_BIT]  = enable;
        rdata[ACT_BIT] = activeFlag;
      end
      SEL_FLAG: rdata[PERMIT_BIT] = permit;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/brk_ctl.sv
module brk_ctl
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regSel,
  input  logic       actWrBit,
  input  logic       hit,
  input  logic       lastCycle,
  input  logic       instrDone,
  output strobe_t    stb,
  output logic       activeFlag,
  output logic       takePulse
);
  logic pending;
  logic trigger;
  logic swClear;

  always_comb begin
    stb.wrHi   = regWr && (regSel_e'(regSel) == SEL_HI);
    stb.wrLo   = regWr && (regSel_e'(regSel) == SEL_LO);
    stb.wrStat = regWr && (regSel_e'(regSel) == SEL_STAT);
    stb.wrFlag = regWr && (regSel_e'(regSel) == SEL_FLAG);
  end

  assign trigger = hit && !activeFlag && !pending;
  assign swClear = stb.wrStat && !actWrBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeFlag <= 1'b0;
      pending    <= 1'b0;
      takePulse  <= 1'b0;
    end else begin
      if (trigger)      activeFlag <= 1'b1;
      else if (swClear) activeFlag <= 1'b0;

      if (trigger)                           pending <= !lastCycle;
      else if (pending && (instrDone || swClear)) pending <= 1'b0;

      takePulse <= (trigger && lastCycle) || (pending && instrDone && !swClear);
    end
  end
endmodule

// File: rtl/brk_addr_ctrl.sv
module brk_addr_ctrl
  import brk_pkg::*;
#(
  parameter logic [DATA_W-1:0] SWI_OP     = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_NORMAL = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON    = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              lastCycle,
  input  logic              instrDone,
  input  logic              monitorMode,
  output logic              breakTake,
  output logic [DATA_W-1:0] swiOpcode,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              timerFreeze,
  output logic              flagClrAllow
);
  strobe_t stb;
  logic hit, permit, activeFlag;

  brk_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .actWrBit(regWdata[ACT_BIT]), .hit(hit), .lastCycle(lastCycle),
    .instrDone(instrDone), .stb(stb), .activeFlag(activeFlag),
    .takePulse(breakTake)
  );

  brk_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata), .regSel(regSel),
    .activeFlag(activeFlag), .busAddr(busAddr), .busValid(busValid),
    .hit(hit), .permit(permit), .rdata(regRdata)
  );

  assign swiOpcode    = breakTake ? SWI_OP : '0;
  assign vecAddr      = monitorMode ? VEC_MON : VEC_NORMAL;
  assign timerFreeze  = activeFlag;
  assign flagClrAllow = !activeFlag || permit;
endmodule

// File: rtl/brk_addr_chk.sv
module brk_addr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regSel,
  input logic [7:0]  regRdata,
  input logic        lastCycle,
  input logic        monitorMode,
  input logic        breakTake,
  input logic [7:0]  swiOpcode,
  input logic [15:0] vecAddr,
  input logic        timerFreeze,
  input logic        flagClrAllow
);
  // R7
  take_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakTake |=> !breakTake);
  // R6
  last_cycle_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(timerFreeze) && $past(lastCycle)) |-> breakTake);
  // R5
  mid_instr_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(timerFreeze) && !$past(lastCycle)) |-> !breakTake);
  // R8
  vector_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakTake |-> (swiOpcode == 8'h83 &&
                   vecAddr == (monitorMode ? 16'hFEFC : 16'hFFFC)));
  // R9
  freeze_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd2) |-> (regRdata[6] == timerFreeze));
  // R10
  protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerFreeze && regSel == 2'd3 && !regRdata[7]) |-> !flagClrAllow);
  // R10
  idle_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerFreeze |-> flagClrAllow);
endmodule

bind brk_addr_ctrl brk_addr_chk chk (.*);

// File: tb/brk_addr_ctrl_test.sv
`timescale 1ns/100ps
module brk_addr_ctrl_test;
  logic clk = 0, rstN = 0;
  logic [1:0] regSel = 0;
  logic regWr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;
  logic [15:0] busAddr = 0;
  logic busValid = 0, lastCycle = 0, instrDone = 0, monitorMode = 0;
  logic breakTake, timerFreeze, flagClrAllow;
  logic [7:0] swiOpcode;
  logic [15:0] vecAddr;
  int checks = 0, failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brk_addr_ctrl uut (.*);

  function automatic logic [15:0] expVec(input logic mon);
    return mon ? 16'hFEFC : 16'hFFFC;
  endfunction

  task automatic expect16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [1:0] s, input logic [7:0] exp, input string tag);
    regSel = s;
    #0.5;
    expect16({8'h0, regRdata}, {8'h0, exp}, tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    regSel = s; regWdata = d; regWr = 1;
    @(negedge clk);
    regWr = 0; regWdata = 0;
  endtask

  task automatic busCycle(input logic [15:0] a, input logic last);
    busAddr = a; busValid = 1; lastCycle = last;
    @(negedge clk);
    busValid = 0; lastCycle = 0;
  endtask

  task automatic boundary();
    instrDone = 1;
    @(negedge clk);
    instrDone = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdchk(0, 8'h00, "R1 hi"); rdchk(1, 8'h00, "R1 lo");
    rdchk(2, 8'h00, "R1 stat"); rdchk(3, 8'h00, "R1 flag");
    expect16(timerFreeze, 0, "R1 freeze"); expect16(breakTake, 0, "R1 take");
    expect16(flagClrAllow, 1, "R1 allow"); expect16(swiOpcode, 0, "R1 opcode");

    // R2 register map, R11 writing 1 to flag ignored
    wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'hFF); wr(3, 8'hFF);
    rdchk(0, 8'h12, "R2 hi"); rdchk(1, 8'h34, "R2 lo");
    rdchk(2, 8'h80, "R2 R11 stat"); rdchk(3, 8'h80, "R2 flag");
    wr(3, 8'h00);

    // R3 disabled and mismatch
    wr(2, 8'h00);
    busCycle(16'h1234, 1);
    expect16(breakTake, 0, "R3 disabled take"); expect16(timerFreeze, 0, "R3 disabled freeze");
    wr(2, 8'h80);
    busCycle(16'h1235, 1);
    expect16(timerFreeze, 0, "R3 mismatch freeze");
    busCycle(16'h1234, 1); busValid = 0;
    // that cycle matched with lastCycle: R6
    expect16(breakTake, 1, "R6 take");
    expect16(swiOpcode, 8'h83, "R8 opcode"); expect16(vecAddr, 16'hFFFC, "R8 normal vec");
    expect16(timerFreeze, 1, "R9 freeze");
    rdchk(2, 8'hC0, "R4 active");
    expect16(flagClrAllow, 0, "R10 protect");
    @(negedge clk);
    expect16(breakTake, 0, "R7 single");
    busCycle(16'h1234, 1);
    expect16(breakTake, 0, "R7 no retrigger");
    wr(3, 8'h80); expect16(flagClrAllow, 1, "R10 permit");
    wr(3, 8'h00);
    wr(2, 8'hC0); expect16(timerFreeze, 1, "R11 write1 no effect");
    wr(2, 8'h80); expect16(timerFreeze, 0, "R11 clear");
    expect16(flagClrAllow, 1, "R10 after clear");

    // R5 mid-instruction, monitor vector
    monitorMode = 1;
    busCycle(16'h1234, 0);
    expect16(breakTake, 0, "R5 wait"); expect16(timerFreeze, 1, "R5 freeze");
    repeat (3) @(negedge clk);
    expect16(breakTake, 0, "R5 still wait");
    boundary();
    expect16(breakTake, 1, "R5 take");
    expect16(vecAddr, 16'hFEFC, "R8 monitor vec");
    @(negedge clk);
    expect16(breakTake, 0, "R7 pulse end");
    wr(2, 8'h80);
    monitorMode = 0;

    // R11 clear cancels pending
    busCycle(16'h1234, 0);
    wr(2, 8'h80);
    boundary();
    expect16(breakTake, 0, "R11 cancel");
    expect16(timerFreeze, 0, "R11 cancel freeze");

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      logic en, last, mon, hitE;
      a = $urandom; en = $urandom % 2; last = $urandom % 2; mon = $urandom % 2;
      b = ($urandom % 2) ? a : (a ^ (16'h1 << ($urandom % 16)));
      hitE = en && (a == b);
      monitorMode = mon;
      wr(0, a[15:8]); wr(1, a[7:0]); wr(2, {en, 7'h0});
      busCycle(b, last);
      expect16(timerFreeze, hitE, "R3 R9 random freeze");
      expect16(breakTake, hitE && last, "R6 random take");
      if (hitE && !last) begin
        boundary();
        expect16(breakTake, 1, "R5 random take");
      end
      if (breakTake) expect16(vecAddr, expVec(mon), "R8 random vec");
      wr(2, {en, 7'h0});
      expect16(timerFreeze, 0, "R11 random clear");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule